// File: doc/BRIEF.md
# Burst-Ready Bus Cycle Tracker

This block sits on the processor side of a 64-bit front-side bus that can burst. It detects the start of a bus cycle from an active-low address strobe and records the cycle kind and direction given with the strobe. It then counts data transfers by sampling an active-low transfer-ready input on every clock of the active cycle. A plain transfer, a special cycle, or either half of an interrupt acknowledge pair needs one ready sample. A burst needs four. The system side can stretch any transfer with wait states by holding ready high.

On each accepted read transfer, the tracker registers the data bus and its eight parity bits. It presents the data with a two-bit beat number and checks that every byte lane has even parity. A parity error sets a flag that stays set until it is cleared. The tracker also latches the side-band attributes:
- a cacheability input,
- a write-policy input (writeback vs writethrough),
- a write-buffer-empty input, which a mask can disable.

The cacheability and write-policy attributes can be taken early, on the next-address input, if that input arrives before the first ready. When the final expected ready edge is seen, the tracker pulses a done output for one clock and goes back to waiting for the next strobe.

Top module: `bus_cycle_tracker`

## Requirements
- R1: While reset is low and on the first clock after it, every output is zero.
- R2: While no cycle is in progress, a low on `readyN` is ignored: `beatValid` and `cycleDone` stay 0 and the latched attributes keep their values.
- R3: `adsN` low on a clock edge starts a cycle. The next edge on which `adsN` is high ends the address phase. Ready is first sampled on the edge after that one, so a ready low on the edge that ends the address phase counts for nothing.
- R4: On a read, each edge with `readyN` low registers `dataIn` onto `beatData`. It pulses `beatValid` for one clock and gives `beatIndex` as the transfer number, counting 0 to 3. These outputs appear right after that edge. Writes never pulse `beatValid`.
- R5: On each read beat, byte lane k (`dataIn[8k+7:8k]` together with `parIn[k]`) must hold an even number of ones. A failing beat sets `parErr`. `parErr` stays set until an edge with `parErrClr` high and no failing beat.
- R6: `cycType` is latched with the strobe: 00 plain transfer, 01 burst, 10 special cycle, 11 interrupt acknowledge. A burst completes on its fourth ready sample and every other kind on its first. Edges with `readyN` high are wait states that add no transfer.
- R7: `cycleDone` goes high for exactly one clock right after the final ready edge. The tracker is then idle and accepts a new strobe.
- R8: On a ready edge, `wbWt` is latched into `attrWbWt` for reads and writes. `cacheEn` is latched into `attrCacheEn` for reads only. A later ready edge of the same cycle overwrites the value.
- R9: If `nextAddrN` is low on an edge of the data phase before any ready has been sampled, `cacheEn` and `wbWt` are latched on that edge. Their values on every later ready edge of that cycle are ignored.
- R10: On a write ready edge, `wbEmpty` is latched into `attrWbEmpty` unless `maskWbEmpty` is high. When the mask is high, the previous value is kept.
- R11: An interrupt acknowledge pair is two separate cycles, each with its own strobe, one ready sample and its own `cycleDone` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| adsN | input | 1 | Address strobe, active low |
| cycType | input | 2 | Cycle kind, taken with the strobe |
| isWrite | input | 1 | Direction, taken with the strobe (1 = write) |
| readyN | input | 1 | Transfer ready, active low |
| nextAddrN | input | 1 | Next-address request, active low |
| dataIn | input | 64 | Data bus |
| parIn | input | 8 | Byte-lane parity bits |
| cacheEn | input | 1 | Cacheability attribute |
| wbWt | input | 1 | Write policy attribute (1 = writeback) |
| wbEmpty | input | 1 | Write-buffer-empty indication |
| maskWbEmpty | input | 1 | Disables sampling of wbEmpty |
| parErrClr | input | 1 | Clears the sticky parity error |
| beatValid | output | 1 | One-clock pulse per captured read beat |
| beatIndex | output | 2 | Transfer number of the captured beat |
| beatData | output | 64 | Captured read data |
| attrCacheEn | output | 1 | Latched cacheability |
| attrWbWt | output | 1 | Latched write policy |
| attrWbEmpty | output | 1 | Latched write-buffer-empty |
| parErr | output | 1 | Sticky parity error |
| cycleDone | output | 1 | One-clock completion pulse |

## Verification
The tracker is driven with random cycles of every kind and direction. Each transfer gets a random number of wait states, and random values appear on the bus and side-band inputs on every edge.

A ready low is always placed on the edge that ends the address phase. This separates a tracker that starts sampling one edge too early from a correct one, because the early version would count an extra transfer or finish early.

Some cycles assert next-address before the first ready and then change the attributes on later ready edges. This shows whether the early latch actually locks the values.

Some beats carry a single flipped parity bit, some cycles are writes with the mask on or off, and ready is toggled while the bus is idle. Together these show whether parity is checked per lane, whether the mask is honoured, and whether stray readies are ignored.

// File: rtl/bus_trk_pkg.sv
package bus_trk_pkg;

  localparam int BURST_LEN  = 4;
  localparam int BEAT_IDX_W = $clog2(BURST_LEN);

  typedef enum logic [1:0] {
    CYC_SINGLE  = 2'b00,
    CYC_BURST   = 2'b01,
    CYC_SPECIAL = 2'b10,
    CYC_INTACK  = 2'b11
  } cycKind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ADDR = 2'b01,
    ST_DATA = 2'b10
  } trkState_e;

  // Strobes from control to datapath, one clock each
  typedef struct packed {
    logic                  beatStb;
    logic [BEAT_IDX_W-1:0] beatIdx;
    logic                  ceStb;
    logic                  wtStb;
    logic                  weStb;
    logic                  doneStb;
  } trkStrobe_t;

endpackage

// File: rtl/bus_trk_ctrl.sv
module bus_trk_ctrl
  import bus_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       adsN,
  input  logic [1:0] cycType,
  input  logic       isWrite,
  input  logic       readyN,
  input  logic       nextAddrN,
  input  logic       maskWbEmpty,
  output trkStrobe_t strobe
);

  trkState_e             state;
  logic [BEAT_IDX_W-1:0] beatCnt;
  logic                  burstQ;
  logic                  writeQ;
  logic                  naLock;

  logic rdyHit;
  logic naHit;
  logic lastBeat;

  always_comb begin
    rdyHit   = (state == ST_DATA) && !readyN;
    naHit    = (state == ST_DATA) && !nextAddrN && !naLock &&
               (beatCnt == '0) && readyN;
    lastBeat = rdyHit && (!burstQ || (beatCnt == BEAT_IDX_W'(BURST_LEN - 1)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
      burstQ  <= 1'b0;
      writeQ  <= 1'b0;
      naLock  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (!adsN) begin
            state   <= ST_ADDR;
            burstQ  <= (cycKind_e'(cycType) == CYC_BURST);
            writeQ  <= isWrite;
            beatCnt <= '0;
            naLock  <= 1'b0;
          end
        end
        ST_ADDR: begin
          if (adsN) state <= ST_DATA;
        end
        ST_DATA: begin
          if (naHit) naLock <= 1'b1;
          if (rdyHit) beatCnt <= beatCnt + 1'b1;
          if (lastBeat) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.beatStb = rdyHit && !writeQ;
    strobe.beatIdx = beatCnt;
    strobe.ceStb   = naHit || (rdyHit && !writeQ && !naLock);
    strobe.wtStb   = naHit || (rdyHit && !naLock);
    strobe.weStb   = rdyHit && writeQ && !maskWbEmpty;
    strobe.doneStb = lastBeat;
  end

endmodule

// File: rtl/bus_trk_dp.sv
module bus_trk_dp
  import bus_trk_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  trkStrobe_t            strobe,
  input  logic [DATA_W-1:0]     dataIn,
  input  logic [DATA_W/LANE_W-1:0] parIn,
  input  logic                  cacheEn,
  input  logic                  wbWt,
  input  logic                  wbEmpty,
  input  logic                  parErrClr,
  output logic                  beatValid,
  output logic [BEAT_IDX_W-1:0] beatIndex,
  output logic [DATA_W-1:0]     beatData,
  output logic                  attrCacheEn,
  output logic                  attrWbWt,
  output logic                  attrWbEmpty,
  output logic                  parErr,
  output logic                  cycleDone
);

  localparam int LANES = DATA_W / LANE_W;

  logic [LANES-1:0] laneBad;
  logic             beatBad;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneBad[g] = ^{dataIn[g*LANE_W +: LANE_W], parIn[g]};
  end

  assign beatBad = strobe.beatStb && (|laneBad);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatValid   <= 1'b0;
      beatIndex   <= '0;
      beatData    <= '0;
      attrCacheEn <= 1'b0;
      attrWbWt    <= 1'b0;
      attrWbEmpty <= 1'b0;
      parErr      <= 1'b0;
      cycleDone   <= 1'b0;
    end else begin
      beatValid <= strobe.beatStb;
      cycleDone <= strobe.doneStb;
      if (strobe.beatStb) begin
        beatIndex <= strobe.beatIdx;
        beatData  <= dataIn;
      end
      if (strobe.ceStb) attrCacheEn <= cacheEn;
      if (strobe.wtStb) attrWbWt    <= wbWt;
      if (strobe.weStb) attrWbEmpty <= wbEmpty;
      if (beatBad)        parErr <= 1'b1;
      else if (parErrClr) parErr <= 1'b0;
    end
  end

endmodule

// File: rtl/bus_cycle_tracker.sv
module bus_cycle_tracker
  import bus_trk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        adsN,
  input  logic [1:0]  cycType,
  input  logic        isWrite,
  input  logic        readyN,
  input  logic        nextAddrN,
  input  logic [63:0] dataIn,
  input  logic [7:0]  parIn,
  input  logic        cacheEn,
  input  logic        wbWt,
  input  logic        wbEmpty,
  input  logic        maskWbEmpty,
  input  logic        parErrClr,
  output logic        beatValid,
  output logic [1:0]  beatIndex,
  output logic [63:0] beatData,
  output logic        attrCacheEn,
  output logic        attrWbWt,
  output logic        attrWbEmpty,
  output logic        parErr,
  output logic        cycleDone
);

  trkStrobe_t strobe;

  bus_trk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .adsN        (adsN),
    .cycType     (cycType),
    .isWrite     (isWrite),
    .readyN      (readyN),
    .nextAddrN   (nextAddrN),
    .maskWbEmpty (maskWbEmpty),
    .strobe      (strobe)
  );

  bus_trk_dp #(.DATA_W(64), .LANE_W(8)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .dataIn      (dataIn),
    .parIn       (parIn),
    .cacheEn     (cacheEn),
    .wbWt        (wbWt),
    .wbEmpty     (wbEmpty),
    .parErrClr   (parErrClr),
    .beatValid   (beatValid),
    .beatIndex   (beatIndex),
    .beatData    (beatData),
    .attrCacheEn (attrCacheEn),
    .attrWbWt    (attrWbWt),
    .attrWbEmpty (attrWbEmpty),
    .parErr      (parErr),
    .cycleDone   (cycleDone)
  );

endmodule

// File: rtl/bus_trk_chk.sv
module bus_trk_chk
  import bus_trk_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       readyN,
  input logic       parErrClr,
  input trkStrobe_t strobe,
  input logic       beatValid,
  input logic       attrWbWt,
  input logic       parErr,
  input logic       cycleDone
);

  // R7: completion is a single-clock pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  // R4: a captured beat always follows a sampled ready
  assert_beat_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    beatValid |-> $past(!readyN));

  // R6: completion only on a ready edge
  assert_done_ready_R6: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> $past(!readyN));

  // R5: the error flag only rises together with a beat
  assert_parerr_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parErr) |-> beatValid);

  // R5: clear works when no beat arrives
  assert_parerr_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (parErrClr && !strobe.beatStb) |=> !parErr);

  // R9: write-policy attribute moves only on a strobe from control
  assert_attr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wtStb |=> $stable(attrWbWt));

endmodule

bind bus_cycle_tracker bus_trk_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .readyN    (readyN),
  .parErrClr (parErrClr),
  .strobe    (strobe),
  .beatValid (beatValid),
  .attrWbWt  (attrWbWt),
  .parErr    (parErr),
  .cycleDone (cycleDone)
);

// File: tb/bus_cycle_tracker_tb.sv
`timescale 1ns/1ps
module bus_cycle_tracker_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adsN = 1'b1;
  logic [1:0]  cycType = 2'b00;
  logic        isWrite = 1'b0;
  logic        readyN = 1'b1;
  logic        nextAddrN = 1'b1;
  logic [63:0] dataIn = '0;
  logic [7:0]  parIn = '0;
  logic        cacheEn = 1'b0;
  logic        wbWt = 1'b0;
  logic        wbEmpty = 1'b0;
  logic        maskWbEmpty = 1'b0;
  logic        parErrClr = 1'b0;
  logic        beatValid;
  logic [1:0]  beatIndex;
  logic [63:0] beatData;
  logic        attrCacheEn, attrWbWt, attrWbEmpty, parErr, cycleDone;

  int nChecks = 0;
  int nFails  = 0;
  bit expCe = 0, expWt = 0, expWe = 0, expPar = 0;
  logic [63:0] expData = '0;
  logic [1:0]  expIdx = '0;

  always #2 clk = ~clk;

  bus_cycle_tracker u_dut (
    .clk(clk), .rstN(rstN), .adsN(adsN), .cycType(cycType), .isWrite(isWrite),
    .readyN(readyN), .nextAddrN(nextAddrN), .dataIn(dataIn), .parIn(parIn),
    .cacheEn(cacheEn), .wbWt(wbWt), .wbEmpty(wbEmpty), .maskWbEmpty(maskWbEmpty),
    .parErrClr(parErrClr), .beatValid(beatValid), .beatIndex(beatIndex),
    .beatData(beatData), .attrCacheEn(attrCacheEn), .attrWbWt(attrWbWt),
    .attrWbEmpty(attrWbEmpty), .parErr(parErr), .cycleDone(cycleDone)
  );

  function automatic logic [7:0] goodPar(input logic [63:0] d);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) p[k] = ^d[k*8 +: 8];
    return p;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  task automatic randBus();
    dataIn  = {$urandom, $urandom};
    parIn   = goodPar(dataIn);
    cacheEn = 1'($urandom);
    wbWt    = 1'($urandom);
    wbEmpty = 1'($urandom);
  endtask

  task automatic chkAttrs(input string req);
    chk(req, {61'd0, attrCacheEn, attrWbWt, attrWbEmpty}, {61'd0, expCe, expWt, expWe});
  endtask

  // One complete bus cycle with expected values computed along the way
  task automatic doCycle(input logic [1:0] ct, input bit wr, input bit useNa,
                         input int maxWait, input bit badPar);
    int  nb = (ct == 2'b01) ? 4 : 1;
    bit  lock = 0;
    int  waits;
    @(negedge clk);
    adsN = 1'b0; cycType = ct; isWrite = wr; readyN = 1'b1; nextAddrN = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    adsN = 1'b1; readyN = 1'b0; nextAddrN = 1'b1; randBus();  // R3: ignored
    @(posedge clk); #1;
    chk("R3 ready on address-phase end", {62'd0, beatValid, cycleDone}, 64'd0);
    for (int b = 0; b < nb; b++) begin
      waits = (maxWait > 0) ? int'($urandom % (maxWait + 1)) : 0;
      if (b == 0 && useNa && waits == 0) waits = 1;
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        readyN = 1'b1; randBus();
        if (b == 0) nextAddrN = !(useNa && w == 0);
        else        nextAddrN = 1'($urandom);
        if (b == 0 && useNa && w == 0) begin
          expCe = cacheEn; expWt = wbWt; lock = 1;
        end
        @(posedge clk); #1;
        chk("R6 wait state", {62'd0, beatValid, cycleDone}, 64'd0);
      end
      @(negedge clk);
      readyN = 1'b0; randBus();
      nextAddrN = (b == 0) ? 1'b1 : 1'($urandom);
      if (badPar && b == 0) parIn = parIn ^ (8'h01 << ($urandom % 8));
      if (!wr) begin
        expData = dataIn; expIdx = 2'(b);
        if (!lock) expCe = cacheEn;
        if (badPar && b == 0) expPar = 1;
      end
      if (!lock) expWt = wbWt;
      if (wr && !maskWbEmpty) expWe = wbEmpty;
      @(posedge clk); #1;
      if (!wr) begin
        chk("R4 beatValid", {63'd0, beatValid}, 64'd1);
        chk("R4 beatData", beatData, expData);
        chk("R4 beatIndex", {62'd0, beatIndex}, {62'd0, expIdx});
      end else begin
        chk("R4 no beat on write", {63'd0, beatValid}, 64'd0);
      end
      chk((ct == 2'b11) ? "R11 done per ack cycle" : "R6 done on final ready",
          {63'd0, cycleDone}, {63'd0, (b == nb - 1)});
      chk("R5 parErr", {63'd0, parErr}, {63'd0, expPar});
    end
    @(negedge clk);
    readyN = 1'b1; nextAddrN = 1'b1; randBus();
    @(posedge clk); #1;
    chk("R7 done one clock", {62'd0, beatValid, cycleDone}, 64'd0);
    if (useNa)   chkAttrs("R9 early attributes");
    else if (wr) chkAttrs("R10 write attributes");
    else         chkAttrs("R8 read attributes");
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset outputs", {beatValid, beatIndex, attrCacheEn, attrWbWt, attrWbEmpty,
        parErr, cycleDone, 56'd0} | {8'd0, beatData[55:0]} | {56'd0, beatData[63:56]}, 64'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    chk("R1 after reset", {62'd0, beatValid, cycleDone}, 64'd0);

    // R2: stray readies while idle
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); readyN = 1'($urandom); nextAddrN = 1'($urandom); randBus();
      @(posedge clk); #1;
      chk("R2 idle ready ignored", {62'd0, beatValid, cycleDone}, 64'd0);
    end
    chkAttrs("R2 attributes held");

    // Directed corners
    doCycle(2'b00, 0, 0, 0, 0);          // R6 single read
    doCycle(2'b01, 0, 0, 0, 0);          // R6 back-to-back burst
    doCycle(2'b01, 0, 0, 3, 1);          // R5 burst with waits and bad parity
    @(negedge clk); parErrClr = 1'b1;
    @(posedge clk); #1; expPar = 0;
    chk("R5 clear", {63'd0, parErr}, 64'd0);
    @(negedge clk); parErrClr = 1'b0;
    doCycle(2'b01, 0, 1, 2, 0);          // R9 early attribute on burst
    maskWbEmpty = 1'b0;
    doCycle(2'b00, 1, 0, 1, 0);          // R10 write sampled
    maskWbEmpty = 1'b1;
    doCycle(2'b01, 1, 0, 1, 0);          // R10 write masked
    doCycle(2'b11, 0, 0, 1, 0);          // R11 first ack
    doCycle(2'b11, 0, 0, 1, 0);          // R11 second ack
    doCycle(2'b10, 1, 0, 2, 0);          // R6 special

    // Random cycles
    for (int i = 0; i < 60; i++) begin
      maskWbEmpty = 1'($urandom);
      if (($urandom % 5) == 0) begin
        @(negedge clk); parErrClr = 1'b1;
        @(posedge clk); #1; expPar = 0;
        chk("R5 clear", {63'd0, parErr}, 64'd0);
        @(negedge clk); parErrClr = 1'b0;
      end
      doCycle(2'($urandom), 1'($urandom), (($urandom % 4) == 0),
              int'($urandom % 4), (($urandom % 6) == 0));
    end
    summary();
  end

endmodule